// File: doc/BRIEF.md
# Frame-Sync Sampler and Qualifier

This block takes an external frame-sync waveform and decides whether it can be trusted to align locally generated 2 kHz timing. The sync line changes on the falling edge of the reference. The block captures it on a strobe that marks the reference rising edge. A two-bit phase code moves the effective capture point by whole half-periods of the reference, which compensates for board skew. The captured value is then retimed on a slower resample tick, and its falling transitions are compared against a local boundary counter that marks one tick in every `PERIOD` resample ticks.

A sync source becomes qualified only after its falling edge has landed on the local boundary for `QUAL_COUNT` boundaries in a row. One boundary without an edge, or one edge away from a boundary, withdraws qualification at once. An alignment request is raised only while the source is qualified, the loop is reported locked, and the function is enabled. Otherwise the downstream alignment generators are left to free-run.

Top module: `fsframe_qualifier`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `qualified` and `align_req` are 0.
- R2: `sync_in` is sampled on every clock into a history. On a clock with `smp_en` high, one tap of that history is captured, at a delay of `HALF_CLKS` times the following number of half-periods: code 2'b00 nominal = 2, 2'b01 half-period early = 3, 2'b10 half-period late = 1, 2'b11 full-period late = 0. A sync input that is late by the amount a code names therefore gives the same result as an on-time input with code 2'b00.
- R3: A significant edge is found on a clock with `rsmp_en` high when the captured value held at the previous resample tick was 1 and the captured value held now is 0. Rising transitions are never significant.
- R4: The boundary counter is cleared while `fs_enable` is low. It advances once per resample tick. The boundary is the tick numbered n, counting from 0 at the first tick with enable high, for which n mod `PERIOD` = `PERIOD`-1.
- R5: `qualified` rises on the clock of the `QUAL_COUNT`-th consecutive boundary tick that carries a significant edge, and not earlier.
- R6: A boundary tick without a significant edge clears `qualified` and the consecutive-hit count on that clock.
- R7: A significant edge on a tick that is not a boundary clears `qualified` and the consecutive-hit count on that clock.
- R8: A clock with `fs_enable` low clears `qualified`, the hit count and the boundary counter.
- R9: `align_req` equals `qualified` AND `dpll_locked` AND `fs_enable`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Capture strobe, marks the reference rising edge |
| rsmp_en | input | 1 | Resample tick from the loop-derived clock |
| sync_in | input | 1 | External frame-sync input |
| phase_code | input | 2 | Expected-phase offset code |
| dpll_locked | input | 1 | Loop lock indication |
| fs_enable | input | 1 | Function enable |
| qualified | output | 1 | Sync source is qualified |
| align_req | output | 1 | Request to align the output generators |

## Verification
The bench builds the block with `PERIOD`=8, `QUAL_COUNT`=4 and `HALF_CLKS`=1, and strobes capture and resample on every second clock. With these values a full qualification takes 62 clocks, so within a few hundred clocks the bench can place sync edges on the boundary and one tick to either side. Dropped edges, stray edges and requalification after a loss also fit in that span. Because one half-period equals one clock, every phase code can be paired with a sync shifted by the amount it names, and also with a sync shifted so that its captured edge misses the boundary by exactly one tick.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    PH_NOMINAL    = 2'b00,
    PH_EARLY_HALF = 2'b01,
    PH_LATE_HALF  = 2'b10,
    PH_LATE_FULL  = 2'b11
  } fsq_phase_e;

  // Half reference periods of history between the live input and the captured tap.
  function automatic int unsigned phase_halves(input logic [1:0] code);
    case (fsq_phase_e'(code))
      PH_NOMINAL:    return 2;
      PH_EARLY_HALF: return 3;
      PH_LATE_HALF:  return 1;
      default:       return 0;
    endcase
  endfunction

  // Length of the history line that covers the widest offset.
  function automatic int unsigned history_depth(input int unsigned half_clks);
    return 3 * half_clks;
  endfunction

  // Next value of a counter that wraps after period-1.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned period);
    return (cur == period - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/fsq_phase_sampler.sv
module fsq_phase_sampler
  import fsq_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       sync_in,
  input  logic [1:0] phase_code,
  output logic       held_o
);
  localparam int unsigned DEPTH = history_depth(HALF_CLKS);
  localparam int unsigned TAPW  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] hist;
  logic [DEPTH:0]   taps;
  logic [TAPW-1:0]  tap_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '1;
    else        hist <= {hist[DEPTH-2:0], sync_in};
  end

  assign taps[0] = sync_in;
  for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
    assign taps[i] = hist[i-1];
  end

  assign tap_idx = TAPW'(phase_halves(phase_code) * HALF_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_o <= 1'b1;
    else if (smp_en) held_o <= taps[tap_idx];
  end
endmodule

// File: rtl/fsq_fall_detect.sv
module fsq_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic held_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b1;
    else if (tick) prev_q <= held_i;
  end

  assign fall_o = tick & prev_q & ~held_i;
endmodule

// File: rtl/fsq_boundary_ctr.sv
module fsq_boundary_ctr
  import fsq_pkg::*;
#(
  parameter int unsigned PERIOD = 3240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic boundary_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!en)  cnt_q <= '0;
    else if (tick) cnt_q <= CW'(wrap_next(32'(cnt_q), PERIOD));
  end

  assign boundary_o = en & tick & (cnt_q == CW'(PERIOD - 1));
endmodule

// File: rtl/fsq_qualifier.sv
module fsq_qualifier #(
  parameter int unsigned QUAL_COUNT = 64,
  localparam int unsigned HW = $clog2(QUAL_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          boundary_i,
  input  logic          fall_i,
  output logic          qualified_o,
  output logic          hit_o,
  output logic          miss_o,
  output logic [HW-1:0] hits_o
);
  assign hit_o  = boundary_i & fall_i;
  assign miss_o = boundary_i ^ fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qualified_o <= 1'b0;
      hits_o      <= '0;
    end else if (!en || miss_o) begin
      qualified_o <= 1'b0;
      hits_o      <= '0;
    end else if (hit_o && !qualified_o) begin
      hits_o <= hits_o + 1'b1;
      if (hits_o == HW'(QUAL_COUNT - 1)) qualified_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fsframe_qualifier.sv
module fsframe_qualifier #(
  parameter int unsigned HALF_CLKS  = 1,
  parameter int unsigned PERIOD     = 3240,
  parameter int unsigned QUAL_COUNT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       rsmp_en,
  input  logic       sync_in,
  input  logic [1:0] phase_code,
  input  logic       dpll_locked,
  input  logic       fs_enable,
  output logic       qualified,
  output logic       align_req
);
  localparam int unsigned HW = $clog2(QUAL_COUNT + 1);

  logic          held;
  logic          fall_evt;
  logic          boundary_evt;
  logic          hit_evt;
  logic          miss_evt;
  logic [HW-1:0] hit_cnt;

  fsq_phase_sampler #(.HALF_CLKS(HALF_CLKS)) u_smp (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_in(sync_in),
    .phase_code(phase_code), .held_o(held)
  );

  fsq_fall_detect u_fall (
    .clk(clk), .rst_n(rst_n), .tick(rsmp_en), .held_i(held), .fall_o(fall_evt)
  );

  fsq_boundary_ctr #(.PERIOD(PERIOD)) u_bnd (
    .clk(clk), .rst_n(rst_n), .en(fs_enable), .tick(rsmp_en), .boundary_o(boundary_evt)
  );

  fsq_qualifier #(.QUAL_COUNT(QUAL_COUNT)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(fs_enable), .boundary_i(boundary_evt),
    .fall_i(fall_evt), .qualified_o(qualified), .hit_o(hit_evt),
    .miss_o(miss_evt), .hits_o(hit_cnt)
  );

  assign align_req = qualified & dpll_locked & fs_enable;
endmodule

// File: rtl/fsframe_qualifier_chk.sv
module fsframe_qualifier_chk #(
  parameter int unsigned QUAL_COUNT = 64,
  localparam int unsigned HW = $clog2(QUAL_COUNT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsmp_en,
  input logic          fs_enable,
  input logic          qualified,
  input logic          align_req,
  input logic          fall_evt,
  input logic          boundary_evt,
  input logic          hit_evt,
  input logic [HW-1:0] hit_cnt
);
  assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> rsmp_en);

  assert_boundary_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_evt |-> (rsmp_en && fs_enable));

  assert_qual_rise_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(hit_evt && fs_enable));

  assert_hits_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= HW'(QUAL_COUNT));

  assert_missing_edge_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_evt && !fall_evt) |=> (!qualified && hit_cnt == '0));

  assert_stray_edge_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !boundary_evt) |=> (!qualified && hit_cnt == '0));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_enable |=> (!qualified && hit_cnt == '0));

  assert_align_follows_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qualified) |-> !align_req);
endmodule

bind fsframe_qualifier fsframe_qualifier_chk #(.QUAL_COUNT(QUAL_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsmp_en(rsmp_en), .fs_enable(fs_enable),
  .qualified(qualified), .align_req(align_req), .fall_evt(fall_evt),
  .boundary_evt(boundary_evt), .hit_evt(hit_evt), .hit_cnt(hit_cnt)
);

// File: tb/fsframe_qualifier_test.sv
`timescale 1ns/1ps
module fsframe_qualifier_test;
  localparam int P   = 8;
  localparam int Q   = 4;
  localparam int H   = 1;
  localparam int OFF = 2*P - 6;   // edge index of the first nominal falling input edge

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_en = 1'b0, rsmp_en = 1'b0, sync_in = 1'b1;
  logic [1:0] phase_code = 2'b00;
  logic dpll_locked = 1'b0, fs_enable = 1'b0;
  logic qualified, align_req;

  int checks = 0, fails = 0;
  int kk = 0, shift = 0, drop_m = -1, glitch_m = -1;
  logic en_v = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsframe_qualifier #(.HALF_CLKS(H), .PERIOD(P), .QUAL_COUNT(Q)) uut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rsmp_en(rsmp_en), .sync_in(sync_in),
    .phase_code(phase_code), .dpll_locked(dpll_locked), .fs_enable(fs_enable),
    .qualified(qualified), .align_req(align_req)
  );

  // Vector table: phase code, input shift in clocks, lock, expected qualified.
  localparam int NV = 9;
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 0, 3, 1, 0, 0};
  localparam int V_SHIFT[NV] = '{0, -1, 1, 2, 2, 0, 1, 0, -8};
  localparam int V_LOCK [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam int V_EXPQ [NV] = '{1, 1, 1, 1, 0, 0, 0, 1, 0};

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Input level at edge k: low for P edges starting at each nominal fall point.
  function automatic logic sync_at(input int k);
    int base, ph, m;
    logic low;
    base = k - shift - OFF;
    ph   = ((base % (2*P)) + 2*P) % (2*P);
    m    = (base + 2*P*100) / (2*P) - 100;
    low  = (ph < P);
    if (m == drop_m) low = 1'b0;
    if (m == glitch_m && ph >= P + 2 && ph < P + 6) low = 1'b1;
    return !low;
  endfunction

  task automatic step();
    @(negedge clk);
    fs_enable = en_v;
    smp_en    = en_v && (kk % 2 == 0);
    rsmp_en   = smp_en;
    sync_in   = sync_at(kk);
    @(posedge clk);
    kk++;
    #1;
  endtask

  task automatic run_to(input int e);
    while (kk < e) step();
  endtask

  task automatic restart(input int code, input int sh, input int lock);
    @(negedge clk);
    fs_enable = 1'b0; smp_en = 1'b0; rsmp_en = 1'b0;
    @(posedge clk);
    #1;
    phase_code = 2'(code); shift = sh; dpll_locked = lock[0];
    drop_m = -1; glitch_m = -1; en_v = 1'b1; kk = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "qualified in reset", qualified, 1'b0);
    check("R1", "align_req in reset", align_req, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "qualified after release", qualified, 1'b0);

    // Table walk: R2 phase codes, R3 polarity, R4 boundary placement, R9 gating.
    for (int v = 0; v < NV; v++) begin
      restart(V_CODE[v], V_SHIFT[v], V_LOCK[v]);
      run_to(2*P*(Q+2));
      check("R2 R3 R4", $sformatf("vector %0d qualified", v), qualified, V_EXPQ[v][0]);
      check("R9", $sformatf("vector %0d align_req", v), align_req,
            V_EXPQ[v][0] & V_LOCK[v][0]);
    end

    // R5 exact count, then R6 one missing edge and requalification.
    restart(0, 0, 1);
    drop_m = Q + 1;
    run_to(2*Q*P - 2);
    check("R5", "one hit short", qualified, 1'b0);
    run_to(2*Q*P - 1);
    check("R5", "on final hit", qualified, 1'b1);
    check("R9", "align when all true", align_req, 1'b1);
    run_to(2*(Q+2)*P - 2);
    check("R6", "before missing edge", qualified, 1'b1);
    run_to(2*(Q+2)*P - 1);
    check("R6", "after missing edge", qualified, 1'b0);
    check("R9", "align after loss", align_req, 1'b0);
    run_to(2*(2*Q+2)*P - 2);
    check("R6", "count restarted", qualified, 1'b0);
    run_to(2*(2*Q+2)*P - 1);
    check("R6", "requalified", qualified, 1'b1);

    // R7 stray falling edge between boundaries.
    restart(0, 0, 1);
    glitch_m = Q + 1;
    run_to(2*P*(Q+2) + P);
    check("R7", "before stray edge", qualified, 1'b1);
    run_to(2*P*(Q+2) + P + 1);
    check("R7", "after stray edge", qualified, 1'b0);

    // R9 lock drop, then R8 enable drop.
    restart(0, 0, 1);
    run_to(2*Q*P);
    check("R9", "qualified before lock drop", qualified, 1'b1);
    dpll_locked = 1'b0; #1;
    check("R9", "align with lock low", align_req, 1'b0);
    check("R9", "qualified kept with lock low", qualified, 1'b1);
    dpll_locked = 1'b1; #1;
    check("R9", "align restored", align_req, 1'b1);
    en_v = 1'b0;
    step();
    check("R8", "qualified after disable", qualified, 1'b0);
    check("R8", "align after disable", align_req, 1'b0);
    en_v = 1'b1;
    restart(0, 0, 1);
    run_to(2*Q*P - 2);
    check("R8", "no leftover hits", qualified, 1'b0);
    run_to(2*Q*P);
    check("R8", "fresh count qualifies", qualified, 1'b1);

    // R1 reset in mid-run.
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1", "qualified on async reset", qualified, 1'b0);
    check("R1", "align on async reset", align_req, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule